// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block samples a bank of digital input lines and turns selected transitions or level patterns on the low group of lines into a single level-sensitive interrupt. A host reaches it over a plain 32-bit register bus: a byte address, write and read strobes, write data and combinational read data. It can read the synchronised lines, program two per-channel selection masks, pick the trigger semantics and the enable through a control word, and collect the latched event pattern from a status word. Reading that word also clears it.

The block has two trigger semantics. In edge mode (OR), each selected channel reports its chosen transition as it happens, and any one of them raises an event. In level mode (AND), the block raises one event when every selected channel holds its required level at the same time. The level trigger then stays locked until a selected line changes level. Both modes use the same pair of masks. The first mask selects rising edges or high levels. The second mask selects falling edges or low levels.

Top module: `cos_irq_top`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Address 0x00 returns all LINE_W synchronised input lines. A change on `lineIn` shows up there after the second rising clock edge, and not after the first.
- R3: The masks at 0x04 (rise/high) and 0x08 (fall/low) read back their low IRQ_W bits, with zeros above. The control word at 0x10 reads back only bit 1 (1 = level/AND mode, 0 = edge/OR mode) and bit 2 (interrupt enable). Its other bits read zero.
- R4: In edge mode, a rising edge on a channel set in the 0x04 mask sets that channel's status bit. A falling edge on a channel set in the 0x08 mask does the same.
- R5: In edge mode, a channel set in both masks sets its status bit on either edge.
- R6: Lines at or above IRQ_W, and channels set in neither mask, never set a status bit.
- R7: In level mode, an event happens only when every channel selected in either mask matches its level: high for the 0x04 mask, low for the 0x08 mask. The event ORs the set of selected channels into the status word.
- R8: After a level-mode event, no further event happens until a selected line changes level. Changes on unselected lines do not unlock it.
- R9: In level mode, a channel set in both masks can never be satisfied, so no event happens.
- R10: A read of 0x0C returns the status pattern in its low IRQ_W bits and clears it. An event detected in the same cycle as the clearing read is kept.
- R11: `irq` is high exactly while the enable bit is set and the status word is non-zero. Clearing the enable bit and setting it again leaves the status word intact.
- R12: Writes to 0x00, 0x0C or an unmapped address change no register. Reads of an unmapped address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | LINE_W | Asynchronous digital input lines |
| addr | input | 5 | Register byte address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; a read of 0x0C clears status |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid while rdEn is high |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: 32 lines, of which 16 can interrupt. This puts both the interrupt-capable channels and a band of plain data lines within reach, so the bench can show that toggling lines 16 to 31 never reaches the status word. With 16 interrupt channels, random masks and inputs in edge mode cover mixed rise, fall and both-edge selections. Level-mode stimulus is restricted to four channels, so that full matches, lock and re-arm occur often. The bench also times one input edge so that its detection lands in the same cycle as a clearing status read.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int REG_ADDR_W = 5;
  localparam logic [REG_ADDR_W-1:0] ADDR_INPUT  = 5'h00;
  localparam logic [REG_ADDR_W-1:0] ADDR_RISEHI = 5'h04;
  localparam logic [REG_ADDR_W-1:0] ADDR_FALLLO = 5'h08;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 5'h0C;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 5'h10;
  localparam int CTRL_AND_BIT = 1;
  localparam int CTRL_EN_BIT  = 2;

  // Strobes from the bus/control side to the detection datapath
  typedef struct packed {
    logic statusClear;  // status read this cycle
    logic cfgChange;    // mask or control written this cycle
  } strobe_t;
endpackage

// File: rtl/cos_control.sv
module cos_control
  import cos_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LINE_W = 32,
  parameter int IRQ_W  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic [LINE_W-1:0]     lineSample,
  input  logic [IRQ_W-1:0]      status,
  input  logic                  pending,
  output logic [IRQ_W-1:0]      riseMask,
  output logic [IRQ_W-1:0]      fallMask,
  output logic                  andMode,
  output logic                  irqEnable,
  output strobe_t               strb,
  output logic                  irq
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseMask  <= '0;
      fallMask  <= '0;
      andMode   <= 1'b0;
      irqEnable <= 1'b0;
    end else if (wrEn) begin
      case (addr)
        ADDR_RISEHI: riseMask <= wrData[IRQ_W-1:0];
        ADDR_FALLLO: fallMask <= wrData[IRQ_W-1:0];
        ADDR_CTRL: begin
          andMode   <= wrData[CTRL_AND_BIT];
          irqEnable <= wrData[CTRL_EN_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.statusClear = rdEn && (addr == ADDR_STATUS);
    strb.cfgChange   = wrEn && (addr == ADDR_RISEHI || addr == ADDR_FALLLO ||
                                addr == ADDR_CTRL);
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (addr)
        ADDR_INPUT:  rdData[LINE_W-1:0] = lineSample;
        ADDR_RISEHI: rdData[IRQ_W-1:0]  = riseMask;
        ADDR_FALLLO: rdData[IRQ_W-1:0]  = fallMask;
        ADDR_STATUS: rdData[IRQ_W-1:0]  = status;
        ADDR_CTRL: begin
          rdData[CTRL_AND_BIT] = andMode;
          rdData[CTRL_EN_BIT]  = irqEnable;
        end
        default: ;
      endcase
    end
  end

  assign irq = irqEnable && pending;

  // R3
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_CTRL) |=> (andMode == $past(wrData[CTRL_AND_BIT])));

  // R12
  ro_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addr == ADDR_STATUS || addr == ADDR_INPUT)) |=>
      ($stable(riseMask) && $stable(fallMask) && $stable(irqEnable)));

endmodule

// File: rtl/cos_datapath.sv
module cos_datapath
  import cos_pkg::*;
#(
  parameter int LINE_W = 32,
  parameter int IRQ_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] lineIn,
  input  logic [IRQ_W-1:0]  riseMask,
  input  logic [IRQ_W-1:0]  fallMask,
  input  logic              andMode,
  input  strobe_t           strb,
  output logic [LINE_W-1:0] lineSample,
  output logic [IRQ_W-1:0]  status,
  output logic              pending
);

  logic [LINE_W-1:0] syncA, syncB;
  logic [IRQ_W-1:0]  prevS;
  logic [IRQ_W-1:0]  cur, sel, edgeHit, lvlOk, selChange, newBits;
  logic              locked, andFire;

  // Two-flop synchroniser plus one history stage for the interrupt channels
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevS <= '0;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
      prevS <= syncB[IRQ_W-1:0];
    end
  end

  assign lineSample = syncB;
  assign cur        = syncB[IRQ_W-1:0];
  assign sel        = riseMask | fallMask;
  assign selChange  = (cur ^ prevS) & sel;

  for (genvar c = 0; c < IRQ_W; c++) begin : g_chan
    assign edgeHit[c] = (riseMask[c] & cur[c] & ~prevS[c]) |
                        (fallMask[c] & ~cur[c] & prevS[c]);
    assign lvlOk[c]   = ~sel[c] |
                        ((~riseMask[c] | cur[c]) & (~fallMask[c] | ~cur[c]));
  end

  assign andFire = andMode && (|sel) && (&lvlOk) && !locked;
  assign newBits = andMode ? (andFire ? sel : '0) : edgeHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
      locked <= 1'b0;
    end else begin
      status <= (strb.statusClear ? '0 : status) | newBits;
      if (strb.cfgChange)   locked <= 1'b0;
      else if (andFire)     locked <= 1'b1;
      else if (|selChange)  locked <= 1'b0;
    end
  end

  assign pending = |status;

  // R10
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statusClear |=> ((status & $past(status)) == $past(status)));

  // R8
  and_single_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    andFire |=> !andFire);

  // R6
  no_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (riseMask == '0 && fallMask == '0 && !strb.statusClear) |=> $stable(status));

  // R9
  overlap_never_chk: assert property (@(posedge clk) disable iff (!rstN)
    (andMode && (riseMask & fallMask) != '0) |-> !andFire);

endmodule

// File: rtl/cos_irq_top.sv
module cos_irq_top
  import cos_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LINE_W = 32,
  parameter int IRQ_W  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINE_W-1:0]     lineIn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic                  irq
);

  logic [LINE_W-1:0] lineSample;
  logic [IRQ_W-1:0]  status, riseMask, fallMask;
  logic              pending, andMode, irqEnable;
  strobe_t           strb;

  cos_control #(.DATA_W(DATA_W), .LINE_W(LINE_W), .IRQ_W(IRQ_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .lineSample(lineSample),
    .status(status), .pending(pending), .riseMask(riseMask),
    .fallMask(fallMask), .andMode(andMode), .irqEnable(irqEnable),
    .strb(strb), .irq(irq)
  );

  cos_datapath #(.LINE_W(LINE_W), .IRQ_W(IRQ_W)) dp_i (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .riseMask(riseMask),
    .fallMask(fallMask), .andMode(andMode), .strb(strb),
    .lineSample(lineSample), .status(status), .pending(pending)
  );

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqEnable) && $past(pending) && !$past(strb.statusClear) &&
     $stable(irqEnable)) |-> irq);

endmodule

// File: tb/cos_irq_top_tb_top.sv
module cos_irq_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lineIn = '0;
  logic [4:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cos_irq_top dut_i (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk); lineIn = v;
    settle();
  endtask

  function automatic logic [15:0] orHits(input logic [15:0] o, input logic [15:0] n,
                                         input logic [15:0] rm, input logic [15:0] fm);
    return (rm & n & ~o) | (fm & ~n & o);
  endfunction

  function automatic bit lvlMatch(input logic [15:0] v, input logic [15:0] rm,
                                  input logic [15:0] fm);
    return ((rm | fm) != 0) && ((rm & ~v) == 0) && ((fm & v) == 0);
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, prevIn, nv;
    logic [15:0] rm, fm, expSt;
    bit          lk;
    r = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a <= 16; a += 4) begin
      busRead(a[4:0], r);
      check("R1 reset reg", r, 32'h0);
    end
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R2 input register and its two-edge latency
    @(negedge clk); lineIn = 32'hDEAD_0000;
    @(negedge clk); addr = 5'h00; rdEn = 1'b1; #1 r = rdData;
    check("R2 after one edge", r, 32'h0);
    @(negedge clk); #1 r = rdData;
    check("R2 after two edges", r, 32'hDEAD_0000);
    rdEn = 1'b0;

    // R3 readback widths
    busWrite(5'h04, 32'hFFFF_FFFF); busRead(5'h04, r);
    check("R3 rise mask", r, 32'h0000_FFFF);
    busWrite(5'h08, 32'hA5A5_1234); busRead(5'h08, r);
    check("R3 fall mask", r, 32'h0000_1234);
    busWrite(5'h10, 32'hFFFF_FFFF); busRead(5'h10, r);
    check("R3 ctrl", r, 32'h0000_0006);
    busWrite(5'h10, 0); busWrite(5'h04, 0); busWrite(5'h08, 0);

    // R12 writes to read-only / unmapped addresses
    busWrite(5'h0C, 32'hFFFF); busWrite(5'h00, 32'h1234); busWrite(5'h14, 32'hFFFF);
    busRead(5'h0C, r); check("R12 status untouched", r, 0);
    busRead(5'h00, r); check("R12 input untouched", r, 32'hDEAD_0000);
    busRead(5'h04, r); check("R12 mask untouched", r, 0);
    busRead(5'h14, r); check("R12 unmapped read", r, 0);

    // R4 directed edge mode
    drive(32'h0); busRead(5'h0C, r);
    busWrite(5'h04, 32'h1); busWrite(5'h08, 32'h2); busWrite(5'h10, 32'h4);
    drive(32'h3);
    busRead(5'h0C, r); check("R4 rise only bit0", r, 32'h1);
    drive(32'h0);
    busRead(5'h0C, r); check("R4 fall only bit1", r, 32'h2);

    // R6 upper lines and unselected channels
    drive(32'hFFFF_0004); drive(32'h0);
    busRead(5'h0C, r); check("R6 no status", r, 0);

    // R5 both masks
    busWrite(5'h04, 32'h1); busWrite(5'h08, 32'h1);
    drive(32'h1); busRead(5'h0C, r); check("R5 rising", r, 32'h1);
    drive(32'h0); busRead(5'h0C, r); check("R5 falling", r, 32'h1);

    // R11 irq and enable toggle
    drive(32'h1);
    check("R11 irq high", {31'd0, irq}, 32'd1);
    busWrite(5'h10, 32'h0);
    check("R11 irq off", {31'd0, irq}, 32'd0);
    busWrite(5'h10, 32'h4);
    check("R11 irq back", {31'd0, irq}, 32'd1);
    busRead(5'h0C, r); check("R11 status kept", r, 32'h1);
    @(negedge clk);
    check("R11 irq cleared", {31'd0, irq}, 32'd0);

    // R10 event in the same cycle as the clearing read
    busWrite(5'h04, 32'h3); busWrite(5'h08, 32'h0);
    drive(32'h0);
    busRead(5'h0C, r);
    drive(32'h1);
    @(negedge clk); lineIn = 32'h3;
    @(negedge clk);
    @(negedge clk); addr = 5'h0C; rdEn = 1'b1; #1 r = rdData;
    check("R10 read value", r, 32'h1);
    @(negedge clk); rdEn = 1'b0;
    settle();
    busRead(5'h0C, r); check("R10 event kept", r, 32'h2);

    // R4/R5/R6 random edge mode
    prevIn = 32'h3;
    for (int blk = 0; blk < 4; blk++) begin
      rm = $urandom; fm = $urandom;
      busWrite(5'h04, {16'd0, rm}); busWrite(5'h08, {16'd0, fm});
      for (int i = 0; i < 10; i++) begin
        nv = $urandom;
        drive(nv);
        expSt = orHits(prevIn[15:0], nv[15:0], rm, fm);
        prevIn = nv;
        busRead(5'h0C, r); check("R4 random edge", r, {16'd0, expSt});
      end
    end

    // R7/R8 directed level mode
    busWrite(5'h10, 32'h0); busWrite(5'h04, 32'h0); busWrite(5'h08, 32'h0);
    drive(32'h0); busRead(5'h0C, r);
    busWrite(5'h04, 32'h3); busWrite(5'h08, 32'h4); busWrite(5'h10, 32'h6);
    settle();
    drive(32'h1); busRead(5'h0C, r); check("R7 partial no fire", r, 0);
    drive(32'h3); busRead(5'h0C, r); check("R7 full match", r, 32'h7);
    drive(32'h23); busRead(5'h0C, r); check("R8 unselected stays locked", r, 0);
    drive(32'h27); busRead(5'h0C, r); check("R8 mismatch", r, 0);
    drive(32'h23); busRead(5'h0C, r); check("R8 rearmed fire", r, 32'h7);

    // R9 overlapping masks in level mode
    busWrite(5'h10, 32'h0); busWrite(5'h04, 32'h1); busWrite(5'h08, 32'h1);
    busRead(5'h0C, r);
    busWrite(5'h10, 32'h6);
    drive(32'h0); drive(32'h1); drive(32'h0);
    busRead(5'h0C, r); check("R9 never fires", r, 0);

    // R7/R8 random level mode on four channels
    prevIn = 32'h0;
    for (int blk = 0; blk < 4; blk++) begin
      busWrite(5'h10, 32'h0);
      rm = 16'($urandom_range(1, 15));
      fm = 16'($urandom_range(0, 15)) & ~rm;
      busWrite(5'h04, {16'd0, rm}); busWrite(5'h08, {16'd0, fm});
      busRead(5'h0C, r);
      busWrite(5'h10, 32'h6);
      settle();
      lk = 1'b0; expSt = '0;
      if (lvlMatch(prevIn[15:0], rm, fm)) begin lk = 1'b1; expSt = rm | fm; end
      busRead(5'h0C, r); check("R7 level on enable", r, {16'd0, expSt});
      for (int i = 0; i < 10; i++) begin
        nv = {28'd0, 4'($urandom)};
        drive(nv);
        expSt = '0;
        if (((nv[15:0] ^ prevIn[15:0]) & (rm | fm)) != 0) lk = 1'b0;
        if (!lk && lvlMatch(nv[15:0], rm, fm)) begin lk = 1'b1; expSt = rm | fm; end
        prevIn = nv;
        busRead(5'h0C, r); check("R8 random level", r, {16'd0, expSt});
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule